// File: doc/BRIEF.md
# Four-Component Multiplicative Congruential Generator

This block produces a stream of uniform 24-bit fractions in [0, 1). It holds four independent first-order multiplicative congruential components. Each component keeps one 24-bit state word and, on every advance, replaces it with its multiplier times the state, reduced by its own prime modulus. The four normalised states are added together and the integer part is dropped. The result appears as a 24-bit binary fraction.

Each component's modulus, multiplier and starting state are written at run time through a load port. A whole set of four (modulus, multiplier) pairs forms one substream, so loading a different set switches the block to another independent stream. Moduli are expected in the range 16718909 to 16776971 and multipliers in the range 112 to 127. Software supplies three precomputed values for each component along with these: the quotient floor(m/a), the remainder m mod a, and a fixed-point reciprocal of the modulus.

The modular product never forms the full 31-bit value a·x mod m by division. It uses the split a·(x mod q) − (m mod a)·floor(x/q), followed by one conditional add of m. This split is exact when a² < m and x < m. The load port raises an error flag when the multiplier breaks the first of these conditions.

Top module: `mcg4_gen`

## Requirements
- R1: While rstN is low and after its release, before any other stimulus, fracOut, fracValid and paramErr are all 0.
- R2: A clock edge with ldValid high stores ldModulus, ldMult, ldQuot, ldRem and ldRecip into component ldSel, where ldSel value k (0 to 3) selects component k. The same edge sets that component's state to ldSeed.
- R3: At each edge with genEn high and ldValid low, every component state x becomes (a·x) mod m exactly, given a² < m, x < m, q = floor(m/a) and r = m mod a.
- R4: A produced fraction equals bits 55 down to 32 of the sum, taken modulo 2^56, of x_k·R_k over the four components. Here x_k is the state after the advance and R_k is that component's loaded reciprocal (intended value floor(2^56/m_k)).
- R5: When genEn is sampled high with ldValid low at edge t, fracValid is high after edge t+1 and fracOut carries the fraction of the states written at edge t. With genEn held high, one fraction is produced per clock.
- R6: genEn is ignored on an edge where ldValid is high: no component advances, and fracValid is low after the following edge.
- R7: A load with ldMult equal to 0, or with ldMult² ≥ ldModulus, marks that component as bad from that edge on. A later valid load to the same component clears the mark. paramErr is high whenever any component is marked bad.
- R8: A state of 0 stays 0. The extreme cases are exact: seed m−1, multipliers 112 and 127, and moduli 16718909 and 16776971.
- R9: When fracValid is low, fracOut keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| ldValid | input | 1 | Load strobe for one component |
| ldSel | input | 2 | Component index for the load |
| ldModulus | input | 24 | Prime modulus m |
| ldMult | input | 7 | Multiplier a |
| ldSeed | input | 24 | Starting state, below m |
| ldQuot | input | 18 | Precomputed floor(m/a) |
| ldRem | input | 7 | Precomputed m mod a |
| ldRecip | input | 34 | Precomputed floor(2^56/m) |
| genEn | input | 1 | Advance all components and produce a fraction |
| fracOut | output | 24 | Fraction of the combined sum, LSB weight 2^-24 |
| fracValid | output | 1 | fracOut updated by the last edge |
| paramErr | output | 1 | Some component holds a multiplier with a = 0 or a² ≥ m |

## Verification
The component states advance on the same edge that samples genEn. The fraction built from those new states appears one edge later together with fracValid. paramErr changes on the load edge itself. The reference model applies each load or advance at the edge where the inputs are sampled, and it delays its expected fraction and valid by one edge. Every output is compared at the falling edge that follows. A load and an advance in the same cycle are exercised directly. So are the bad-multiplier loads, each followed by a repairing reload before the stream resumes.

// File: rtl/mcg4_pkg.sv
package mcg4_pkg;
  localparam int NCOMP    = 4;
  localparam int SELW     = $clog2(NCOMP);
  localparam int XW       = 24;   // state and modulus width
  localparam int AW       = 7;    // multiplier width
  localparam int QW       = 18;   // floor(m/a) width
  localparam int RCPW     = 34;   // reciprocal width
  localparam int RCPSHIFT = 56;   // reciprocal scale 2^RCPSHIFT

  typedef struct packed {
    logic [NCOMP-1:0] ldOne;  // load strobe per component
    logic             adv;    // advance all states
    logic             cap;    // capture combined fraction
  } mcgStrobe_t;
endpackage

// File: rtl/mcg4_ctrl.sv
module mcg4_ctrl
  import mcg4_pkg::*;
#(
  parameter int SW = SELW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ldValid,
  input  logic [SW-1:0] ldSel,
  input  logic          genEn,
  output mcgStrobe_t    strb
);
  logic pendR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendR <= 1'b0;
    else       pendR <= genEn && !ldValid;
  end

  always_comb begin
    strb = '0;
    for (int i = 0; i < NCOMP; i++) begin
      strb.ldOne[i] = ldValid && (ldSel == SW'(i));
    end
    strb.adv = genEn && !ldValid;
    strb.cap = pendR;
  end
endmodule

// File: rtl/mcg4_step.sv
module mcg4_step #(
  parameter int XW = 24,
  parameter int AW = 7,
  parameter int QW = 18
) (
  input  logic [XW-1:0] x,
  input  logic [XW-1:0] m,
  input  logic [AW-1:0] a,
  input  logic [QW-1:0] q,
  input  logic [AW-1:0] r,
  output logic [XW-1:0] y
);
  localparam int HW = AW + 1;       // floor(x/q) <= a fits here
  localparam int CW = XW + HW;      // compare width for shifted q
  localparam int PW = XW + AW;      // product width

  logic [CW-1:0]     accW, trial;
  logic [HW-1:0]     hi;
  logic [XW-1:0]     lo;
  logic [PW-1:0]     prodA, prodR;
  logic signed [PW:0] diff;

  // short restoring division: quotient is at most a
  always_comb begin
    accW = CW'(x);
    hi   = '0;
    for (int i = HW - 1; i >= 0; i--) begin
      trial = CW'(q) << i;
      if (accW >= trial) begin
        accW  = accW - trial;
        hi[i] = 1'b1;
      end
    end
    lo = accW[XW-1:0];
  end

  always_comb begin
    prodA = PW'(a) * PW'(lo);
    prodR = PW'(r) * PW'(hi);
    diff  = $signed({1'b0, prodA}) - $signed({1'b0, prodR});
    if (diff < 0) diff = diff + $signed({1'b0, PW'(m)});
    y = diff[XW-1:0];
  end
endmodule

// File: rtl/mcg4_dp.sv
module mcg4_dp
  import mcg4_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  mcgStrobe_t      strb,
  input  logic [XW-1:0]   ldModulus,
  input  logic [AW-1:0]   ldMult,
  input  logic [XW-1:0]   ldSeed,
  input  logic [QW-1:0]   ldQuot,
  input  logic [AW-1:0]   ldRem,
  input  logic [RCPW-1:0] ldRecip,
  output logic [XW-1:0]   fracOut,
  output logic            fracValid,
  output logic            paramErr
);
  localparam int FRACLSB = RCPSHIFT - XW;

  logic [XW-1:0]       ldSq;
  logic                ldBad;
  logic [RCPSHIFT-1:0] term [NCOMP];
  logic [RCPSHIFT-1:0] fracSum;
  logic [NCOMP-1:0]    badV;

  assign ldSq  = XW'(ldMult) * XW'(ldMult);
  assign ldBad = (ldMult == '0) || (ldSq >= ldModulus);

  for (genvar g = 0; g < NCOMP; g++) begin : g_comp
    logic [XW-1:0]   modR, stR, stNext;
    logic [AW-1:0]   mulR, remR;
    logic [QW-1:0]   quotR;
    logic [RCPW-1:0] recipR;
    logic            badR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modR <= '0; stR <= '0; mulR <= '0; remR <= '0;
        quotR <= '0; recipR <= '0; badR <= 1'b0;
      end else if (strb.ldOne[g]) begin
        modR   <= ldModulus;
        mulR   <= ldMult;
        quotR  <= ldQuot;
        remR   <= ldRem;
        recipR <= ldRecip;
        stR    <= ldSeed;
        badR   <= ldBad;
      end else if (strb.adv) begin
        stR <= stNext;
      end
    end

    mcg4_step #(.XW(XW), .AW(AW), .QW(QW)) u_step (
      .x(stR), .m(modR), .a(mulR), .q(quotR), .r(remR), .y(stNext)
    );

    assign term[g] = RCPSHIFT'(stR) * RCPSHIFT'(recipR);
    assign badV[g] = badR;
  end

  always_comb begin
    fracSum = '0;
    for (int k = 0; k < NCOMP; k++) fracSum = fracSum + term[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fracOut   <= '0;
      fracValid <= 1'b0;
    end else begin
      fracValid <= strb.cap;
      if (strb.cap) fracOut <= XW'(fracSum >> FRACLSB);
    end
  end

  assign paramErr = |badV;
endmodule

// File: rtl/mcg4_gen.sv
module mcg4_gen
  import mcg4_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            ldValid,
  input  logic [SELW-1:0] ldSel,
  input  logic [XW-1:0]   ldModulus,
  input  logic [AW-1:0]   ldMult,
  input  logic [XW-1:0]   ldSeed,
  input  logic [QW-1:0]   ldQuot,
  input  logic [AW-1:0]   ldRem,
  input  logic [RCPW-1:0] ldRecip,
  input  logic            genEn,
  output logic [XW-1:0]   fracOut,
  output logic            fracValid,
  output logic            paramErr
);
  mcgStrobe_t strb;

  mcg4_ctrl #(.SW(SELW)) u_ctrl (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldSel(ldSel),
    .genEn(genEn), .strb(strb)
  );

  mcg4_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ldModulus(ldModulus), .ldMult(ldMult), .ldSeed(ldSeed),
    .ldQuot(ldQuot), .ldRem(ldRem), .ldRecip(ldRecip),
    .fracOut(fracOut), .fracValid(fracValid), .paramErr(paramErr)
  );
endmodule

// File: rtl/mcg4_chk.sv
module mcg4_chk
  import mcg4_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          ldValid,
  input logic [XW-1:0] ldModulus,
  input logic [AW-1:0] ldMult,
  input logic          genEn,
  input logic [XW-1:0] fracOut,
  input logic          fracValid,
  input logic          paramErr
);
  logic [XW-1:0] sq;
  assign sq = XW'(ldMult) * XW'(ldMult);

  // R5
  gen_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (genEn && !ldValid) |=> ##1 fracValid);

  // R6
  load_blocks_gen_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldValid |=> ##1 !fracValid);

  // R9
  frac_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fracValid |-> $stable(fracOut));

  // R7
  bad_mult_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && ((ldMult == '0) || (sq >= ldModulus))) |=> paramErr);
endmodule

bind mcg4_gen mcg4_chk u_chk (
  .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldModulus(ldModulus),
  .ldMult(ldMult), .genEn(genEn), .fracOut(fracOut),
  .fracValid(fracValid), .paramErr(paramErr)
);

// File: tb/mcg4_gen_bench.sv
module mcg4_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldValid = 1'b0;
  logic [1:0]  ldSel = '0;
  logic [23:0] ldModulus = '0;
  logic [6:0]  ldMult = '0;
  logic [23:0] ldSeed = '0;
  logic [17:0] ldQuot = '0;
  logic [6:0]  ldRem = '0;
  logic [33:0] ldRecip = '0;
  logic        genEn = 1'b0;
  logic [23:0] fracOut;
  logic        fracValid;
  logic        paramErr;

  mcg4_gen u_mcg4_gen (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldSel(ldSel),
    .ldModulus(ldModulus), .ldMult(ldMult), .ldSeed(ldSeed),
    .ldQuot(ldQuot), .ldRem(ldRem), .ldRecip(ldRecip),
    .genEn(genEn), .fracOut(fracOut), .fracValid(fracValid),
    .paramErr(paramErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference
  longint unsigned mM[4], mA[4], mR[4], st[4];
  bit              bad[4];
  bit              pend, expValid, expErr;
  longint unsigned expFrac;
  int              vectors = 0, miscompares = 0;
  string           curReq = "R1";

  function automatic longint unsigned fracOf();
    longint unsigned s = 0;
    for (int k = 0; k < 4; k++) s += st[k] * mR[k];
    return (s >> 32) & 64'hFFFFFF;
  endfunction

  task automatic chk(string what, longint unsigned got, longint unsigned exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", curReq, what, got, exp, $time);
    end
  endtask

  task automatic cycle();
    bit nv;
    longint unsigned nf;
    @(posedge clk);
    if (!rstN) begin
      for (int k = 0; k < 4; k++) begin
        mM[k] = 0; mA[k] = 0; mR[k] = 0; st[k] = 0; bad[k] = 0;
      end
      pend = 0; expValid = 0; expFrac = 0;
    end else begin
      nv = pend;
      nf = pend ? fracOf() : expFrac;
      if (ldValid) begin
        mM[ldSel] = ldModulus; mA[ldSel] = ldMult; mR[ldSel] = ldRecip;
        st[ldSel] = ldSeed;
        bad[ldSel] = (ldMult == 0) || (ldMult * ldMult >= ldModulus);
      end else if (genEn) begin
        for (int k = 0; k < 4; k++) st[k] = (mA[k] * st[k]) % mM[k];
      end
      pend = genEn && !ldValid;
      expValid = nv; expFrac = nf;
    end
    expErr = bad[0] | bad[1] | bad[2] | bad[3];
    @(negedge clk);
    chk("fracValid", fracValid, expValid);
    chk("fracOut", fracOut, expFrac);
    chk("paramErr", paramErr, expErr);
  endtask

  task automatic setLoad(int idx, longint unsigned m, longint unsigned a, longint unsigned seed);
    ldValid   = 1'b1;
    ldSel     = 2'(idx);
    ldModulus = 24'(m);
    ldMult    = 7'(a);
    ldSeed    = 24'(seed);
    ldQuot    = (a == 0) ? 18'd0 : 18'(m / a);
    ldRem     = (a == 0) ? 7'd0 : 7'(m % a);
    ldRecip   = 34'((64'd1 << 56) / m);
  endtask

  task automatic loadComp(int idx, longint unsigned m, longint unsigned a, longint unsigned seed);
    setLoad(idx, m, a, seed);
    cycle();
    ldValid = 1'b0;
  endtask

  task automatic run(int n, int every);
    for (int i = 0; i < n; i++) begin
      genEn = (i % every) == 0;
      cycle();
    end
    genEn = 1'b0;
  endtask

  initial begin
    curReq = "R1";
    repeat (3) cycle();
    rstN = 1'b1;
    cycle();

    // extreme parameters, zero seed and top seed
    curReq = "R2 R7 R8";
    loadComp(0, 16718909, 112, 16718908);
    loadComp(1, 16776971, 127, 1);
    loadComp(2, 16750001, 120, 0);
    loadComp(3, 16760017, 115, 12345678);
    curReq = "R3 R4 R5 R8";
    run(40, 1);
    cycle();

    curReq = "R9 R5";
    run(30, 3);
    cycle();

    // load and advance requested together
    curReq = "R6";
    genEn = 1'b1;
    setLoad(3, 16760017, 115, 999);
    cycle();
    ldValid = 1'b0;
    genEn = 1'b0;
    cycle();
    cycle();
    curReq = "R3 R4 R6";
    run(10, 1);
    cycle();

    // bad multipliers, then repair
    curReq = "R7";
    loadComp(1, 16000, 127, 5);
    cycle();
    loadComp(1, 16776971, 127, 7);
    cycle();
    loadComp(2, 16750001, 0, 3);
    cycle();
    loadComp(2, 16750001, 113, 3);
    cycle();
    curReq = "R3 R4 R7";
    run(20, 1);
    cycle();

    // several substreams
    for (int s = 0; s < 8; s++) begin
      curReq = "R2 R3 R4";
      for (int k = 0; k < 4; k++) begin
        longint unsigned m = 16718909 + (s * 4 + k) * 1801;
        loadComp(k, m, 112 + ((s * 4 + k) % 16), (s * 1000003 + k * 777777 + 1) % m);
      end
      run(150, 1);
      cycle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule